// File: doc/BRIEF.md
# Flooding Min-Sum Decoder for a Length-10 Regular (3,6) Code

This block corrects a ten-bit word of a rate-1/2 regular low-density parity-check code from ten signed soft channel values. A parallel array of ten bit-node units and five check-node units evaluates one complete min-sum message exchange per clock. The thirty check-to-bit edge messages sit in registers, so every unit in an iteration reads only values written at the end of the previous one.

A start strobe captures the soft inputs and clears all edge messages. The block then iterates until the hard decisions satisfy all five parity checks, or until the iteration limit is reached. It reports the decoded word, a one-cycle completion pulse, a flag that tells whether a valid codeword was found, and the number of check updates that were applied. Soft values are 8-bit two's complement numbers with two integer and five fraction bits. A larger (more positive) value means a 0 bit is more likely.

Top module: `ldpc_flood_dec`

## Requirements
- R1: While reset is high and after it, until the first decode completes, `done`, `success`, `dec_bits` and `iter_count` are all zero.
- R2: Check j (j = 0..4) covers the bit positions set in its mask, where bit c is column c: j0 = 0000111111, j1 = 0111000111, j2 = 1011011001, j3 = 1101101010, j4 = 1110110100. Every column is in exactly three checks and every check has six columns. A word with `success` = 1 satisfies all five checks.
- R3: The hard decision of bit n is 1 exactly when the channel value plus the incoming check messages of bit n is negative. A zero total gives 0. Bit n of `dec_bits` is column n, and soft value n is `llr_in[8n+7:8n]`.
- R4: In each iteration, the message from bit n to check j is the bit total minus the message that j last sent to n. The message from check j to bit n has magnitude equal to the smallest magnitude among the other five inputs of j. It is negative when an odd number of those other inputs are negative.
- R5: Decoding stops at the first evaluation whose hard decisions give a zero syndrome. It then reports `success` = 1, and `iter_count` equals the number of check updates applied (0 if the channel word is already valid).
- R6: If the syndrome is still nonzero after 16 check updates, decoding stops with `success` = 0, `iter_count` = 16, and the hard decisions of that final evaluation.
- R7: `done` is high for exactly one cycle per decode. `dec_bits`, `success` and `iter_count` change only in that cycle and hold afterwards.
- R8: A start strobe always begins a fresh decode: it reloads the channel values, clears the edge messages and the iteration counter, and abandons any decode in progress.
- R9: With the start strobe sampled at clock edge E0, `done` is high in the cycle that follows edge E(k+1), where k is the reported `iter_count`.
- R10: Bit-to-check messages saturate symmetrically to the range -127..+127, so a channel value of -128 is accepted without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures `llr_in` and begins a decode |
| llr_in | input | 80 | Ten soft channel values, value n in bits 8n+7..8n |
| dec_bits | output | 10 | Decoded hard decisions, bit n is column n |
| done | output | 1 | One-cycle pulse when a decode completes |
| success | output | 1 | High when the decoded word satisfies every check |
| iter_count | output | 5 | Check updates applied in the last decode |

## Verification
The bench aims at a channel word that is already valid, where a design that counts one iteration too many would report 1 and arrive one cycle late. It also uses an all-zero input with one small negative value, which keeps every message at zero and forces the full 16-iteration failure: an off-by-one limit would stop at 15 or 17, or report success. A -128 input next to +127 values drives the bit-node subtraction past the clamp, where missing saturation would wrap the sign. A restart is issued while a decode is running, and a design that keeps old messages would return the stale word's result.

// File: rtl/ldpc_pkg.sv
package ldpc_pkg;

    localparam int N_VAR = 10;
    localparam int N_CHK = 5;
    localparam int DEG_V = 3;
    localparam int DEG_C = 6;

    // bit c of entry j marks column c as a member of check j
    localparam logic [N_VAR-1:0] H_ROWS [N_CHK] = '{
        10'b0000111111,
        10'b0111000111,
        10'b1011011001,
        10'b1101101010,
        10'b1110110100
    };

    typedef enum logic {ST_IDLE, ST_RUN} dec_state_e;

    // k-th column belonging to check r
    function automatic int chk_col(int r, int k);
        int res = 0;
        int cnt = 0;
        for (int c = 0; c < N_VAR; c++) begin
            if (H_ROWS[r][c]) begin
                if (cnt == k) res = c;
                cnt++;
            end
        end
        return res;
    endfunction

    // j-th check attached to column n
    function automatic int var_row(int n, int j);
        int res = 0;
        int cnt = 0;
        for (int r = 0; r < N_CHK; r++) begin
            if (H_ROWS[r][n]) begin
                if (cnt == j) res = r;
                cnt++;
            end
        end
        return res;
    endfunction

    // position of column n among the inputs of check r
    function automatic int chk_slot(int r, int n);
        int cnt = 0;
        for (int c = 0; c < n; c++) if (H_ROWS[r][c]) cnt++;
        return cnt;
    endfunction

    // position of check r among the edges of column n
    function automatic int var_slot(int n, int r);
        int cnt = 0;
        for (int q = 0; q < r; q++) if (H_ROWS[q][n]) cnt++;
        return cnt;
    endfunction

endpackage

// File: rtl/ldpc_vnu.sv
module ldpc_vnu #(
    parameter int W  = 8,
    parameter int DV = 3
) (
    input  logic signed [W-1:0] ch_llr,
    input  logic signed [W-1:0] c2v [DV],
    output logic signed [W-1:0] v2c [DV],
    output logic                hard_bit
);
    localparam int SW = W + $clog2(DV + 1);
    localparam logic signed [SW-1:0] HI = SW'(2 ** (W - 1) - 1);
    localparam logic signed [SW-1:0] LO = -HI;

    logic signed [SW-1:0] total;
    logic signed [SW-1:0] diff;

    always_comb begin
        total = SW'(ch_llr);
        for (int j = 0; j < DV; j++) total = total + SW'(c2v[j]);
        hard_bit = total[SW-1];
    end

    always_comb begin
        diff = '0;
        for (int j = 0; j < DV; j++) begin
            diff = total - SW'(c2v[j]);
            if (diff > HI)      v2c[j] = HI[W-1:0];
            else if (diff < LO) v2c[j] = LO[W-1:0];
            else                v2c[j] = diff[W-1:0];
        end
    end
endmodule

// File: rtl/ldpc_cnu.sv
module ldpc_cnu #(
    parameter int W  = 8,
    parameter int DC = 6
) (
    input  logic signed [W-1:0] v2c [DC],
    output logic signed [W-1:0] c2v [DC]
);
    localparam int MW = W - 1;

    logic [MW-1:0] mag [DC];
    logic [DC-1:0] neg;
    logic [MW-1:0] m;
    logic          s;

    always_comb begin
        for (int i = 0; i < DC; i++) begin
            neg[i] = v2c[i][W-1];
            mag[i] = neg[i] ? MW'(-v2c[i]) : v2c[i][MW-1:0];
        end
    end

    always_comb begin
        m = '1;
        s = 1'b0;
        for (int k = 0; k < DC; k++) begin
            m = '1;
            s = 1'b0;
            for (int i = 0; i < DC; i++) begin
                if (i != k) begin
                    if (mag[i] < m) m = mag[i];
                    s = s ^ neg[i];
                end
            end
            c2v[k] = s ? -$signed({1'b0, m}) : $signed({1'b0, m});
        end
    end
endmodule

// File: rtl/ldpc_flood_dec.sv
module ldpc_flood_dec
    import ldpc_pkg::*;
#(
    parameter  int W        = 8,
    parameter  int MAX_ITER = 16,
    localparam int IW       = $clog2(MAX_ITER + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [N_VAR*W-1:0]   llr_in,
    output logic [N_VAR-1:0]     dec_bits,
    output logic                 done,
    output logic                 success,
    output logic [IW-1:0]        iter_count
);
    dec_state_e            state_q;
    logic [IW-1:0]         iter_q;
    logic signed [W-1:0]   ch_q  [N_VAR];
    logic signed [W-1:0]   c2v_q [N_CHK][DEG_C];
    logic signed [W-1:0]   c2v_d [N_CHK][DEG_C];
    logic signed [W-1:0]   v2c   [N_VAR][DEG_V];
    logic [N_VAR-1:0]      hard;
    logic [N_CHK-1:0]      syn;
    logic                  at_limit;

    for (genvar n = 0; n < N_VAR; n++) begin : g_var
        logic signed [W-1:0] vin  [DEG_V];
        logic signed [W-1:0] vout [DEG_V];
        for (genvar j = 0; j < DEG_V; j++) begin : g_edge
            localparam int R = var_row(n, j);
            localparam int S = chk_slot(R, n);
            assign vin[j]    = c2v_q[R][S];
            assign v2c[n][j] = vout[j];
        end
        ldpc_vnu #(.W(W), .DV(DEG_V)) u_vnu (
            .ch_llr   (ch_q[n]),
            .c2v      (vin),
            .v2c      (vout),
            .hard_bit (hard[n])
        );
    end

    for (genvar r = 0; r < N_CHK; r++) begin : g_chk
        logic signed [W-1:0] cin  [DEG_C];
        logic signed [W-1:0] cout [DEG_C];
        for (genvar k = 0; k < DEG_C; k++) begin : g_edge
            localparam int C = chk_col(r, k);
            localparam int S = var_slot(C, r);
            assign cin[k]      = v2c[C][S];
            assign c2v_d[r][k] = cout[k];
        end
        ldpc_cnu #(.W(W), .DC(DEG_C)) u_cnu (
            .v2c (cin),
            .c2v (cout)
        );
        assign syn[r] = ^(hard & H_ROWS[r]);
    end

    assign at_limit = (iter_q == IW'(MAX_ITER));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            iter_q     <= '0;
            done       <= 1'b0;
            success    <= 1'b0;
            dec_bits   <= '0;
            iter_count <= '0;
            for (int n = 0; n < N_VAR; n++) ch_q[n] <= '0;
            for (int r = 0; r < N_CHK; r++)
                for (int k = 0; k < DEG_C; k++) c2v_q[r][k] <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state_q <= ST_RUN;
                iter_q  <= '0;
                for (int n = 0; n < N_VAR; n++) ch_q[n] <= llr_in[n*W +: W];
                for (int r = 0; r < N_CHK; r++)
                    for (int k = 0; k < DEG_C; k++) c2v_q[r][k] <= '0;
            end else if (state_q == ST_RUN) begin
                if (syn == '0 || at_limit) begin
                    state_q    <= ST_IDLE;
                    done       <= 1'b1;
                    success    <= (syn == '0);
                    dec_bits   <= hard;
                    iter_count <= iter_q;
                end else begin
                    iter_q <= iter_q + 1'b1;
                    for (int r = 0; r < N_CHK; r++)
                        for (int k = 0; k < DEG_C; k++) c2v_q[r][k] <= c2v_d[r][k];
                end
            end
        end
    end
endmodule

// File: rtl/ldpc_flood_dec_chk.sv
module ldpc_flood_dec_chk
    import ldpc_pkg::*;
#(
    parameter  int W        = 8,
    parameter  int MAX_ITER = 16,
    localparam int IW       = $clog2(MAX_ITER + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [N_VAR-1:0]   dec_bits,
    input logic               done,
    input logic               success,
    input logic [IW-1:0]      iter_count
);
    logic [N_CHK-1:0] out_syn;

    always_comb begin
        for (int r = 0; r < N_CHK; r++) out_syn[r] = ^(dec_bits & H_ROWS[r]);
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(dec_bits) && $stable(success) && $stable(iter_count)));

    assert_valid_word_R2: assert property (@(posedge clk) disable iff (rst)
        (done && success) |-> (out_syn == '0));

    assert_fail_at_limit_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !success) |-> (iter_count == IW'(MAX_ITER) && out_syn != '0));

    assert_no_done_after_start_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (iter_count <= IW'(MAX_ITER)));
endmodule

bind ldpc_flood_dec ldpc_flood_dec_chk #(.W(W), .MAX_ITER(MAX_ITER)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .dec_bits   (dec_bits),
    .done       (done),
    .success    (success),
    .iter_count (iter_count)
);

// File: tb/ldpc_flood_dec_bench.sv
module ldpc_flood_dec_bench;
    localparam int NV = 10;
    localparam int NC = 5;
    localparam int LIM = 16;
    localparam bit [9:0] HB [5] = '{
        10'b0000111111, 10'b0111000111, 10'b1011011001,
        10'b1101101010, 10'b1110110100
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [79:0] llr_in = '0;
    logic [9:0]  dec_bits;
    logic        done;
    logic        success;
    logic [4:0]  iter_count;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ldpc_flood_dec u_ldpc_flood_dec (
        .clk(clk), .rst(rst), .start(start), .llr_in(llr_in),
        .dec_bits(dec_bits), .done(done), .success(success),
        .iter_count(iter_count)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp127(input int x);
        if (x > 127) return 127;
        if (x < -127) return -127;
        return x;
    endfunction

    function automatic void ref_decode(input int ch[10], output bit [9:0] bits,
                                       output bit ok, output int iters);
        int c2v [5][10];
        int nc2v [5][10];
        int v2c [5][10];
        int tot [10];
        bit [9:0] hd;
        bit [4:0] syn;
        for (int r = 0; r < NC; r++)
            for (int n = 0; n < NV; n++) begin
                c2v[r][n] = 0; nc2v[r][n] = 0; v2c[r][n] = 0;
            end
        ok = 1'b0; iters = 0; bits = '0; hd = '0; syn = '0;
        for (int it = 0; it <= LIM; it++) begin
            for (int n = 0; n < NV; n++) begin
                tot[n] = ch[n];
                for (int r = 0; r < NC; r++) if (HB[r][n]) tot[n] += c2v[r][n];
                hd[n] = (tot[n] < 0);
            end
            for (int r = 0; r < NC; r++) syn[r] = ^(hd & HB[r]);
            bits = hd; iters = it;
            if (syn == '0) begin ok = 1'b1; break; end
            if (it == LIM) break;
            for (int r = 0; r < NC; r++)
                for (int n = 0; n < NV; n++)
                    if (HB[r][n]) v2c[r][n] = clamp127(tot[n] - c2v[r][n]);
            for (int r = 0; r < NC; r++)
                for (int n = 0; n < NV; n++) begin
                    int m;
                    bit s;
                    m = 127; s = 1'b0;
                    if (HB[r][n]) begin
                        for (int c = 0; c < NV; c++) begin
                            if (c != n && HB[r][c]) begin
                                int a;
                                a = (v2c[r][c] < 0) ? -v2c[r][c] : v2c[r][c];
                                if (a < m) m = a;
                                s ^= (v2c[r][c] < 0);
                            end
                        end
                        nc2v[r][n] = s ? -m : m;
                    end
                end
            for (int r = 0; r < NC; r++)
                for (int n = 0; n < NV; n++) c2v[r][n] = nc2v[r][n];
        end
    endfunction

    function automatic bit [4:0] syndrome(input bit [9:0] w);
        bit [4:0] s;
        for (int r = 0; r < NC; r++) s[r] = ^(w & HB[r]);
        return s;
    endfunction

    task automatic pulse_start(input int ch[10]);
        for (int n = 0; n < NV; n++) llr_in[n*8 +: 8] = ch[n][7:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_case(input int ch[10], input string tag);
        bit [9:0] eb;
        bit       eok;
        int       eit;
        int       lat;
        logic [9:0] held;
        ref_decode(ch, eb, eok, eit);
        pulse_start(ch);
        lat = 0;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        chk("R9", {tag, " done seen"}, done, 1);
        chk("R4", {tag, " decoded bits"}, dec_bits, eb);
        chk("R5", {tag, " success flag"}, success, eok);
        chk("R5", {tag, " iteration count"}, iter_count, eit);
        chk("R9", {tag, " latency"}, lat, eit + 1);
        if (success) chk("R2", {tag, " syndrome of word"}, syndrome(dec_bits), 0);
        if (eit == LIM && !eok) chk("R6", {tag, " limit count"}, iter_count, LIM);
        held = dec_bits;
        @(negedge clk);
        chk("R7", {tag, " done one cycle"}, done, 0);
        @(negedge clk);
        chk("R7", {tag, " bits held"}, dec_bits, held);
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int ch[10];
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", done, 0);
        chk("R1", "success in reset", success, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "done idle", done, 0);
        chk("R1", "bits idle", dec_bits, 0);
        chk("R1", "count idle", iter_count, 0);

        // R3: already-valid all-zero word, strongly positive
        for (int n = 0; n < NV; n++) ch[n] = 64;
        run_case(ch, "R3 zero word");
        // R3: all-ones word is valid (every check has even weight)
        for (int n = 0; n < NV; n++) ch[n] = -40;
        run_case(ch, "R3 ones word");
        chk("R3", "ones word bits", dec_bits, 10'h3FF);
        // R3: zero totals decide 0
        for (int n = 0; n < NV; n++) ch[n] = 0;
        run_case(ch, "R3 zero totals");
        chk("R3", "zero totals bits", dec_bits, 0);
        // R6: messages stay zero, never converges
        for (int n = 0; n < NV; n++) ch[n] = 0;
        ch[1] = -1;
        run_case(ch, "R6 stuck");
        chk("R6", "stuck success", success, 0);
        chk("R6", "stuck count", iter_count, LIM);
        chk("R6", "stuck bits", dec_bits, 10'b0000000010);
        // R5: one flipped bit corrected after one update
        for (int n = 0; n < NV; n++) ch[n] = 100;
        ch[0] = -50;
        run_case(ch, "R5 single flip");
        chk("R5", "single flip count", iter_count, 1);
        chk("R5", "single flip bits", dec_bits, 0);
        // R10: -128 beside +127 pushes extrinsic values into the clamp
        for (int n = 0; n < NV; n++) ch[n] = 127;
        ch[0] = -128;
        ch[7] = -128;
        run_case(ch, "R10 clamp");

        // R8: restart while a decode runs
        for (int n = 0; n < NV; n++) ch[n] = 0;
        ch[1] = -1;
        pulse_start(ch);
        repeat (3) @(negedge clk);
        for (int n = 0; n < NV; n++) ch[n] = 90;
        ch[4] = -30;
        run_case(ch, "R8 restart");

        // random mix, R4
        for (int t = 0; t < 90; t++) begin
            int mode;
            mode = int'($urandom_range(0, 2));
            for (int n = 0; n < NV; n++) begin
                if (mode == 2) begin
                    ch[n] = int'($urandom_range(0, 255)) - 128;
                end else begin
                    int v;
                    v = int'($urandom_range(10, 110));
                    if ($urandom_range(0, 4) == 0) v = -int'($urandom_range(0, 60));
                    ch[n] = (mode == 1) ? -v : v;
                    if (ch[n] < -128) ch[n] = -128;
                    if (ch[n] > 127) ch[n] = 127;
                end
            end
            run_case(ch, "R4 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule